// File: doc/BRIEF.md
# Multi-Page-Size Translation Lookaside Buffer

This block is a small, fully associative cache of virtual-to-physical translations for a 32-bit address space. Each cycle it can take one lookup carrying a virtual address. One cycle later it reports one of two outcomes. A hit comes with the physical address and the attributes of the region: endianness, element size and a mixed flag. A miss tells the requester to start a table walk. After the walk, a fill port installs the new translation.

Every entry carries its own region size: 4KB, 64KB, 1MB or 16MB. The size sets how many virtual page-number bits take part in the tag compare. It also sets how many offset bits pass through untranslated into the physical address. A flush input drops all entries at once. Fills pick an empty slot first. When no slot is empty, they take the slot under a round-robin pointer.

The result path is a three-state machine:
- LK_IDLE means no result.
- LK_HIT means a valid translation is presented.
- LK_MISS means a miss is presented.

Each clock edge, any state goes to LK_HIT on a lookup that matches, to LK_MISS on a lookup that matches nothing, and to LK_IDLE when no lookup is made. Reset enters LK_IDLE.

Top module: `mpt_tlb`

## Requirements
- R1: After reset no result is presented (lk_valid_o low) and every entry is empty, so the first lookup misses.
- R2: A lookup made in cycle t gives its result at the clock edge that ends cycle t. lk_valid_o is high exactly in the cycle after a request, with exactly one of lk_hit_o and lk_miss_o set.
- R3: A 4KB entry (size code 2'b00) matches when VA[31:12] equals its tag. The physical address is frame[31:12] joined with VA[11:0].
- R4: A 64KB entry (size code 2'b01) compares only VA[31:16]. The physical address takes bits [31:16] from the frame and bits [15:0] from the VA. Frame bits below bit 16 given at fill are ignored.
- R5: A 1MB entry (size code 2'b10) compares only VA[31:20]. The physical address takes bits [31:20] from the frame and bits [19:0] from the VA. Tag bits below bit 20 given at fill are ignored.
- R6: A 16MB entry (size code 2'b11) compares only VA[31:24]. The physical address takes bits [31:24] from the frame and bits [23:0] from the VA.
- R7: A hit returns the endianness, element size and mixed flag stored with the matching entry.
- R8: A lookup that matches no valid entry reports a miss, with the physical address and all attribute outputs zero.
- R9: A fill writes the lowest-index empty slot when one exists. Otherwise it writes the slot under a round-robin pointer. After every fill the pointer moves to the slot after the one written, wrapping from 7 to 0.
- R10: A flush empties every entry in one cycle and resets the pointer to slot 0. A flush overrides a fill in the same cycle. A lookup in the flush cycle still sees the old contents.
- R11: A lookup in the same cycle as a fill sees the contents from before the fill. The next lookup sees the new entry.
- R12: When several valid entries match, the entry with the lowest index supplies the result, whatever the region sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Empty all entries |
| lk_req_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_valid_o | output | 1 | A lookup result is presented |
| lk_hit_o | output | 1 | Result is a hit |
| lk_miss_o | output | 1 | Result is a miss |
| lk_pa_o | output | 32 | Translated physical address (zero on miss) |
| lk_big_endian_o | output | 1 | Endianness of the hit region |
| lk_elem_sz_o | output | 2 | Element size of the hit region |
| lk_mixed_o | output | 1 | Mixed flag of the hit region |
| fill_i | input | 1 | Install a translation |
| fill_vpn_i | input | 20 | Virtual page number VA[31:12] to install |
| fill_ppn_i | input | 20 | Physical frame number PA[31:12] to install |
| fill_size_i | input | 2 | Region size code: 00 4KB, 01 64KB, 10 1MB, 11 16MB |
| fill_big_endian_i | input | 1 | Endianness attribute |
| fill_elem_sz_i | input | 2 | Element size attribute |
| fill_mixed_i | input | 1 | Mixed attribute |

## Verification
The hardest states to reach from the ports are the cases that depend on timing and history:
- a full buffer whose round-robin pointer has wrapped;
- overlapping entries of different sizes;
- a flush, fill or lookup landing in the same cycle.

The stimulus fills all eight slots in a known order so the pointer wraps back to slot 0. It then shows an eviction by a lookup that used to hit and now misses. It installs a 16MB region and a 4KB page that overlap, in both index orders, to expose the priority. It also raises flush, fill and lookup together in one cycle and checks that the results follow the old contents.

// File: rtl/mpt_tlb_pkg.sv
package mpt_tlb_pkg;

    localparam int unsigned VA_W       = 32;
    localparam int unsigned PAGE_SHIFT = 12;
    localparam int unsigned VPN_W      = VA_W - PAGE_SHIFT;
    localparam int unsigned SZ_STEP    = 4;   // page-number bits dropped per size step

    typedef enum logic [1:0] {
        SZ_4K  = 2'b00,
        SZ_64K = 2'b01,
        SZ_1M  = 2'b10,
        SZ_16M = 2'b11
    } region_sz_e;

    typedef struct packed {
        logic       big_endian;
        logic [1:0] elem_sz;
        logic       mixed;
    } region_attr_t;

    typedef enum logic [1:0] {
        LK_IDLE = 2'b00,
        LK_HIT  = 2'b01,
        LK_MISS = 2'b10
    } lk_state_e;

    // Page-number bits that take part in the compare for a given size.
    function automatic logic [VPN_W-1:0] vpn_mask(input region_sz_e sz);
        logic [VPN_W-1:0] ones;
        ones = '1;
        return ones << (SZ_STEP * int'(sz));
    endfunction

endpackage

// File: rtl/mpt_tlb_entry.sv
module mpt_tlb_entry
    import mpt_tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              wr_i,
    input  logic [VPN_W-1:0]  wr_vpn_i,
    input  logic [VPN_W-1:0]  wr_ppn_i,
    input  region_sz_e        wr_sz_i,
    input  region_attr_t      wr_attr_i,
    input  logic [VPN_W-1:0]  lk_vpn_i,
    output logic              valid_o,
    output logic              match_o,
    output logic [VPN_W-1:0]  ppn_o,
    output region_attr_t      attr_o
);

    logic             vld_q;
    logic [VPN_W-1:0] tag_q;
    logic [VPN_W-1:0] frame_q;
    region_sz_e       sz_q;
    region_attr_t     attr_q;
    logic [VPN_W-1:0] cmp_mask;
    logic [VPN_W-1:0] wr_mask;

    assign wr_mask  = vpn_mask(wr_sz_i);
    assign cmp_mask = vpn_mask(sz_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            tag_q   <= '0;
            frame_q <= '0;
            sz_q    <= SZ_4K;
            attr_q  <= '0;
        end else if (flush_i) begin
            vld_q   <= 1'b0;
        end else if (wr_i) begin
            vld_q   <= 1'b1;
            tag_q   <= wr_vpn_i & wr_mask;
            frame_q <= wr_ppn_i & wr_mask;
            sz_q    <= wr_sz_i;
            attr_q  <= wr_attr_i;
        end
    end

    assign valid_o = vld_q;
    assign match_o = vld_q && ((lk_vpn_i & cmp_mask) == tag_q);
    assign ppn_o   = frame_q | (lk_vpn_i & ~cmp_mask);
    assign attr_o  = attr_q;

endmodule

// File: rtl/mpt_tlb_victim.sv
module mpt_tlb_victim #(
    parameter int unsigned N_ENTRIES = 8,
    localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush_i,
    input  logic                 fill_i,
    input  logic [N_ENTRIES-1:0] valid_i,
    output logic [IDX_W-1:0]     victim_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;

    // Lowest-index empty slot, scanning downward so the lowest wins.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign victim_o = free_found ? free_idx : ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            ptr_q <= '0;
        end else if (fill_i) begin
            ptr_q <= (victim_o == LAST) ? '0 : victim_o + 1'b1;
        end
    end

endmodule

// File: rtl/mpt_tlb_pick.sv
module mpt_tlb_pick
    import mpt_tlb_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 8
) (
    input  logic [N_ENTRIES-1:0]            match_i,
    input  logic [N_ENTRIES-1:0][VPN_W-1:0] ppn_i,
    input  region_attr_t [N_ENTRIES-1:0]    attr_i,
    output logic                            any_o,
    output logic [VPN_W-1:0]                ppn_o,
    output region_attr_t                    attr_o
);

    always_comb begin
        any_o  = |match_i;
        ppn_o  = '0;
        attr_o = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (match_i[i]) begin
                ppn_o  = ppn_i[i];
                attr_o = attr_i[i];
            end
        end
    end

endmodule

// File: rtl/mpt_tlb.sv
module mpt_tlb
    import mpt_tlb_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 8,
    localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              lk_req_i,
    input  logic [VA_W-1:0]   lk_va_i,
    output logic              lk_valid_o,
    output logic              lk_hit_o,
    output logic              lk_miss_o,
    output logic [VA_W-1:0]   lk_pa_o,
    output logic              lk_big_endian_o,
    output logic [1:0]        lk_elem_sz_o,
    output logic              lk_mixed_o,
    input  logic              fill_i,
    input  logic [VPN_W-1:0]  fill_vpn_i,
    input  logic [VPN_W-1:0]  fill_ppn_i,
    input  logic [1:0]        fill_size_i,
    input  logic              fill_big_endian_i,
    input  logic [1:0]        fill_elem_sz_i,
    input  logic              fill_mixed_i
);

    logic [N_ENTRIES-1:0]            ent_valid;
    logic [N_ENTRIES-1:0]            ent_match;
    logic [N_ENTRIES-1:0][VPN_W-1:0] ent_ppn;
    region_attr_t [N_ENTRIES-1:0]    ent_attr;
    logic [IDX_W-1:0]                victim;
    logic                            fill_go;
    region_attr_t                    fill_attr;
    logic                            any_hit;
    logic [VPN_W-1:0]                hit_ppn;
    region_attr_t                    hit_attr;

    lk_state_e        state_q, state_d;
    logic [VA_W-1:0]  pa_q;
    region_attr_t     attr_q;

    assign fill_go   = fill_i && !flush_i;
    assign fill_attr = '{big_endian: fill_big_endian_i,
                         elem_sz:    fill_elem_sz_i,
                         mixed:      fill_mixed_i};

    mpt_tlb_victim #(.N_ENTRIES(N_ENTRIES)) victim_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (flush_i),
        .fill_i   (fill_go),
        .valid_i  (ent_valid),
        .victim_o (victim)
    );

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
        mpt_tlb_entry ent_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush_i   (flush_i),
            .wr_i      (fill_go && (victim == IDX_W'(g))),
            .wr_vpn_i  (fill_vpn_i),
            .wr_ppn_i  (fill_ppn_i),
            .wr_sz_i   (region_sz_e'(fill_size_i)),
            .wr_attr_i (fill_attr),
            .lk_vpn_i  (lk_va_i[VA_W-1:PAGE_SHIFT]),
            .valid_o   (ent_valid[g]),
            .match_o   (ent_match[g]),
            .ppn_o     (ent_ppn[g]),
            .attr_o    (ent_attr[g])
        );
    end

    mpt_tlb_pick #(.N_ENTRIES(N_ENTRIES)) pick_i (
        .match_i (ent_match),
        .ppn_i   (ent_ppn),
        .attr_i  (ent_attr),
        .any_o   (any_hit),
        .ppn_o   (hit_ppn),
        .attr_o  (hit_attr)
    );

    // Next-state logic of the result machine.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_IDLE, LK_HIT, LK_MISS: begin
                if (!lk_req_i)    state_d = LK_IDLE;
                else if (any_hit) state_d = LK_HIT;
                else              state_d = LK_MISS;
            end
            default: state_d = LK_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    // Result data, captured alongside the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_q   <= '0;
            attr_q <= '0;
        end else if (state_d == LK_HIT) begin
            pa_q   <= {hit_ppn, lk_va_i[PAGE_SHIFT-1:0]};
            attr_q <= hit_attr;
        end else begin
            pa_q   <= '0;
            attr_q <= '0;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        lk_valid_o = 1'b0;
        lk_hit_o   = 1'b0;
        lk_miss_o  = 1'b0;
        unique case (state_q)
            LK_IDLE: ;
            LK_HIT: begin
                lk_valid_o = 1'b1;
                lk_hit_o   = 1'b1;
            end
            LK_MISS: begin
                lk_valid_o = 1'b1;
                lk_miss_o  = 1'b1;
            end
            default: ;
        endcase
    end

    assign lk_pa_o         = pa_q;
    assign lk_big_endian_o = attr_q.big_endian;
    assign lk_elem_sz_o    = attr_q.elem_sz;
    assign lk_mixed_o      = attr_q.mixed;

endmodule

// File: rtl/mpt_tlb_chk.sv
module mpt_tlb_chk #(
    parameter int unsigned OFF_W = 12,
    parameter int unsigned PA_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush_i,
    input logic             lk_req_i,
    input logic [OFF_W-1:0] off_i,
    input logic             lk_valid_o,
    input logic             lk_hit_o,
    input logic             lk_miss_o,
    input logic [PA_W-1:0]  lk_pa_o,
    input logic             lk_big_endian_o,
    input logic [1:0]       lk_elem_sz_o,
    input logic             lk_mixed_o
);

    p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_o |-> (lk_hit_o ^ lk_miss_o));

    p_result_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req_i |=> lk_valid_o);

    p_no_result_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req_i |=> !lk_valid_o);

    p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss_o |-> (lk_pa_o == '0 && !lk_big_endian_o && lk_elem_sz_o == 2'b00 && !lk_mixed_o));

    p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req_i && rst_n) |=> (!lk_hit_o || lk_pa_o[OFF_W-1:0] == $past(off_i)));

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush_i) && $past(rst_n) && lk_req_i) |=> lk_miss_o);

endmodule

bind mpt_tlb mpt_tlb_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .flush_i         (flush_i),
    .lk_req_i        (lk_req_i),
    .off_i           (lk_va_i[11:0]),
    .lk_valid_o      (lk_valid_o),
    .lk_hit_o        (lk_hit_o),
    .lk_miss_o       (lk_miss_o),
    .lk_pa_o         (lk_pa_o),
    .lk_big_endian_o (lk_big_endian_o),
    .lk_elem_sz_o    (lk_elem_sz_o),
    .lk_mixed_o      (lk_mixed_o)
);

// File: tb/mpt_tlb_tb_top.sv
module mpt_tlb_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        lk_req_i = 1'b0;
    logic [31:0] lk_va_i = '0;
    logic        lk_valid_o, lk_hit_o, lk_miss_o;
    logic [31:0] lk_pa_o;
    logic        lk_big_endian_o, lk_mixed_o;
    logic [1:0]  lk_elem_sz_o;
    logic        fill_i = 1'b0;
    logic [19:0] fill_vpn_i = '0;
    logic [19:0] fill_ppn_i = '0;
    logic [1:0]  fill_size_i = '0;
    logic        fill_big_endian_i = 1'b0;
    logic [1:0]  fill_elem_sz_i = '0;
    logic        fill_mixed_i = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mpt_tlb dut_i (.*);

    typedef struct packed {
        logic [31:0] va;
        logic        hit;
        logic [31:0] pa;
        logic [3:0]  attr;   // {big_endian, elem_sz[1:0], mixed}
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h1234_5ABC, 1'b1, 32'hAAAA_BABC, 4'hC, 8'd3},  // R3 inside page
        '{32'h1234_6ABC, 1'b0, 32'h0,         4'h0, 8'd3},  // R3 next page
        '{32'h2345_FFFF, 1'b1, 32'h7771_FFFF, 4'h3, 8'd4},  // R4 top of region
        '{32'h2346_0000, 1'b0, 32'h0,         4'h0, 8'd4},  // R4 past region
        '{32'h456A_BCDE, 1'b1, 32'h880A_BCDE, 4'hF, 8'd5},  // R5 masked tag
        '{32'h4570_0000, 1'b0, 32'h0,         4'h0, 8'd5},  // R5 past region
        '{32'h5AFF_FFFF, 1'b1, 32'h03FF_FFFF, 4'h0, 8'd6},  // R6 top of region
        '{32'h5B00_0000, 1'b0, 32'h0,         4'h0, 8'd6},  // R6 past region
        '{32'h0000_0000, 1'b0, 32'h0,         4'h0, 8'd8},  // R8 no entry
        '{32'h2345_0001, 1'b1, 32'h7771_0001, 4'h3, 8'd7}   // R7 attributes
    };

    task automatic check(input string what, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic set_fill(input logic [31:0] va, input logic [31:0] pa,
                            input logic [1:0] sz, input logic [3:0] attr);
        fill_i            = 1'b1;
        fill_vpn_i        = va[31:12];
        fill_ppn_i        = pa[31:12];
        fill_size_i       = sz;
        fill_big_endian_i = attr[3];
        fill_elem_sz_i    = attr[2:1];
        fill_mixed_i      = attr[0];
    endtask

    task automatic do_fill(input logic [31:0] va, input logic [31:0] pa,
                           input logic [1:0] sz, input logic [3:0] attr);
        @(negedge clk);
        set_fill(va, pa, sz, attr);
        @(negedge clk);
        fill_i = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
    endtask

    // Result sampled at the falling edge after the capturing rising edge.
    task automatic expect_result(input string tag, input logic hit,
                                 input logic [31:0] pa, input logic [3:0] attr);
        check({tag, " valid"}, 64'(lk_valid_o), 64'd1);
        check({tag, " hit"},   64'(lk_hit_o),   64'(hit));
        check({tag, " miss"},  64'(lk_miss_o),  64'(!hit));
        check({tag, " pa"},    64'(lk_pa_o),    64'(pa));
        check({tag, " attr"},  64'({lk_big_endian_o, lk_elem_sz_o, lk_mixed_o}), 64'(attr));
    endtask

    task automatic lookup(input string tag, input logic [31:0] va, input logic hit,
                          input logic [31:0] pa, input logic [3:0] attr);
        @(negedge clk);
        lk_req_i = 1'b1;
        lk_va_i  = va;
        @(negedge clk);
        lk_req_i = 1'b0;
        expect_result(tag, hit, pa, attr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 no result in reset", 64'(lk_valid_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 no result after reset", 64'(lk_valid_o), 64'd0);
        lookup("R1 empty after reset", 32'h1234_5000, 1'b0, 32'h0, 4'h0);
        @(negedge clk);
        check("R2 idle after request", 64'(lk_valid_o), 64'd0);

        // Slots 0..3, one of each size; low bits of tag/frame must be ignored.
        do_fill(32'h1234_5000, 32'hAAAA_B000, 2'b00, 4'hC);
        do_fill(32'h2345_0000, 32'h7771_1000, 2'b01, 4'h3);   // R4 frame low bits dropped
        do_fill(32'h456F_F000, 32'h8800_0000, 2'b10, 4'hF);   // R5 tag low bits dropped
        do_fill(32'h5A00_0000, 32'h0300_0000, 2'b11, 4'h0);

        for (int i = 0; i < NV; i++) begin
            lookup($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].va,
                   VECS[i].hit, VECS[i].pa, VECS[i].attr);
        end

        // R2 back-to-back lookups, one result per cycle.
        @(negedge clk);
        lk_req_i = 1'b1; lk_va_i = 32'h1234_5001;
        @(negedge clk);
        expect_result("R2 back-to-back first", 1'b1, 32'hAAAA_B001, 4'hC);
        lk_va_i = 32'h9999_9999;
        @(negedge clk);
        lk_req_i = 1'b0;
        expect_result("R2 back-to-back second", 1'b0, 32'h0, 4'h0);

        // R9: fill slots 4..7, pointer wraps to 0, then evict slot 0 and slot 1.
        for (int i = 4; i < 8; i++)
            do_fill(32'h6000_0000 + (i << 12), 32'h9000_0000 + (i << 12), 2'b00, 4'h2);
        lookup("R9 slot7 present", 32'h6000_7008, 1'b1, 32'h9000_7008, 4'h2);
        do_fill(32'h7000_0000, 32'hB000_0000, 2'b00, 4'h1);
        lookup("R9 slot0 evicted", 32'h1234_5ABC, 1'b0, 32'h0, 4'h0);
        lookup("R9 slot1 kept", 32'h2345_1111, 1'b1, 32'h7771_1111, 4'h3);
        lookup("R9 new entry", 32'h7000_0010, 1'b1, 32'hB000_0010, 4'h1);
        do_fill(32'h7100_0000, 32'hB100_0000, 2'b00, 4'h1);
        lookup("R9 slot1 evicted", 32'h2345_1111, 1'b0, 32'h0, 4'h0);

        // R11: fill and lookup in the same cycle.
        @(negedge clk);
        set_fill(32'h7200_0000, 32'hC000_0000, 2'b00, 4'h6);
        lk_req_i = 1'b1; lk_va_i = 32'h7200_0004;
        @(negedge clk);
        fill_i = 1'b0; lk_req_i = 1'b0;
        expect_result("R11 same-cycle lookup sees old", 1'b0, 32'h0, 4'h0);
        lookup("R11 next lookup sees fill", 32'h7200_0004, 1'b1, 32'hC000_0004, 4'h6);

        // R10: flush with lookup, then flush with fill.
        @(negedge clk);
        flush_i = 1'b1; lk_req_i = 1'b1; lk_va_i = 32'h7000_0010;
        @(negedge clk);
        flush_i = 1'b0; lk_req_i = 1'b0;
        expect_result("R10 lookup in flush cycle", 1'b1, 32'hB000_0010, 4'h1);
        lookup("R10 after flush", 32'h7000_0010, 1'b0, 32'h0, 4'h0);
        @(negedge clk);
        flush_i = 1'b1;
        set_fill(32'h7300_0000, 32'hD000_0000, 2'b00, 4'h1);
        @(negedge clk);
        flush_i = 1'b0; fill_i = 1'b0;
        lookup("R10 flush beats fill", 32'h7300_0000, 1'b0, 32'h0, 4'h0);

        // R12: overlapping entries, lowest index wins in either size order.
        do_flush();
        do_fill(32'h5A00_0000, 32'h0300_0000, 2'b11, 4'h0);
        do_fill(32'h5A12_3000, 32'hDDDD_D000, 2'b00, 4'hA);
        lookup("R12 16MB in slot0 wins", 32'h5A12_3456, 1'b1, 32'h0312_3456, 4'h0);
        do_flush();
        do_fill(32'h5A12_3000, 32'hDDDD_D000, 2'b00, 4'hA);
        do_fill(32'h5A00_0000, 32'h0300_0000, 2'b11, 4'h0);
        lookup("R12 4KB in slot0 wins", 32'h5A12_3456, 1'b1, 32'hDDDD_D456, 4'hA);
        lookup("R12 16MB covers rest", 32'h5A77_0001, 1'b1, 32'h0377_0001, 4'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule